// File: doc/BRIEF.md
# Candidate Confirmation Filter

This block sits in a muon trigger sector pipeline, after candidate formation and before sorting. Each bunch crossing presents one candidate slot for each of eight pads. A slot carries a 3-bit threshold code and a payload of debug fields. The filter decides whether each candidate is confirmed by external evidence from the same crossing. That evidence comes from two sources: a 32-bit vector of calorimeter tile signals and an 8-bit vector of outer-plane flags. A candidate that is not confirmed keeps its payload, but its threshold code is forced to zero, so later stages see no candidate in that slot.

Confirmation is programmable for each pair of pad and threshold. A tile mask word selects the tile signals that may confirm the candidate, and a tile enable bit decides whether tile confirmation is required at all. The three low thresholds also have an 8-bit outer-plane mask and their own enable bit. Masks may overlap freely, so one signal can confirm several thresholds on several pads. The filter has two pipeline stages. The outer-plane check runs first, and the tile check runs in the following cycle. Software loads the masks and enables through a single-cycle register write port.

Top module: `ccf_confirm_filter`

## Requirements
- R1: For each cycle with `in_valid` high, `out_valid` is high exactly two clock cycles later. Back-to-back crossings produce back-to-back results, and `out_valid` is low at all other times.
- R2: Pad p occupies bits [16p+15:16p] of `in_cand`/`out_cand`. The threshold code sits in bits [2:0] of the slot and the 13-bit payload in bits [15:3]. Code 0 means no candidate and leaves the slot unchanged.
- R3: A candidate with code t (1..6) on pad p whose tile enable is set passes only when its tile mask ANDed with `in_tile` of the same crossing is nonzero. Otherwise its code becomes 0.
- R4: When the tile enable for pad p and threshold t is clear, the tile signals have no effect on that candidate.
- R5: A low candidate (code 1..3) whose outer-plane enable is set passes only when its outer-plane mask ANDed with `in_opl` of the same crossing is nonzero. Otherwise its code becomes 0.
- R6: High candidates (code 4..6) are never subject to the outer-plane check, whatever the outer-plane masks and enables hold.
- R7: A rejected candidate keeps its payload bits unchanged.
- R8: A single tile bit may appear in the masks of several pads and thresholds, and it confirms each of them independently.
- R9: A low candidate with both checks enabled passes only if both the outer-plane check and the tile check succeed.
- R10: The configuration address map covers these words:
  - Address 6p+(t-1) is the tile mask for pad p, threshold t.
  - Address 48 holds the low tile enables: bit 4p+j enables threshold j+1.
  - Address 49 holds the high tile enables: bit 4p+j enables threshold j+4.
  - Address 50 holds the outer-plane enables: bit 4p+j enables threshold j+1.
  - Address 51+p holds the outer-plane masks for pad p: bits [8j+7:8j] serve threshold j+1.
  - Writes to addresses 59..63 change nothing.
- R11: A crossing uses the configuration as it stood on the cycle it entered. A write in that same cycle, or while the crossing is in flight, does not affect it. The next crossing sees the write.
- R12: Reset clears every mask and enable, and drives `out_valid` and `out_cand` to zero. After reset every candidate passes unchanged.
- R13: Tile and outer-plane inputs are taken from the same cycle as `in_valid` for the crossing. Signals from a neighbouring crossing do not confirm it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Crossing strobe for the candidate and signal inputs |
| in_cand | input | 128 | Eight candidate slots, 16 bits each |
| in_tile | input | 32 | Tile confirmation signals |
| in_opl | input | 8 | Outer-plane flags |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| out_valid | output | 1 | Filtered crossing strobe |
| out_cand | output | 128 | Filtered candidate slots |

## Verification
The assertions assume that no pad ever carries code 7. The design therefore treats codes 1..6 as the only real candidates, and the stimulus only builds slots with codes 0..6. The stage properties compare each output slot with the same slot one cycle earlier. This relies on the crossing strobe being held low during reset. The bench keeps it low until reset is released and drives all inputs only on falling edges.

// File: rtl/ccf_pkg.sv
package ccf_pkg;
  localparam int THR_W   = 3;
  localparam int NTHR    = 6;
  localparam int NLOW    = 3;
  localparam int SLICE_W = 4;

  function automatic logic thr_is_low(input logic [THR_W-1:0] t);
    return (t >= 3'd1) && (t <= 3'd3);
  endfunction

  function automatic logic thr_is_cand(input logic [THR_W-1:0] t);
    return (t >= 3'd1) && (t <= 3'd6);
  endfunction
endpackage

// File: rtl/ccf_cfg_bank.sv
module ccf_cfg_bank
  import ccf_pkg::*;
#(
  parameter int NPADS = 8,
  parameter int NTILE = 32,
  parameter int NOPL  = 8,
  parameter int AW    = 6,
  parameter int DW    = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic [AW-1:0]                addr,
  input  logic [DW-1:0]                wdata,
  output logic [NPADS*NTHR*NTILE-1:0]  tmask_o,
  output logic [NPADS*NTHR-1:0]        ten_o,
  output logic [NPADS*NLOW*NOPL-1:0]   omask_o,
  output logic [NPADS*NLOW-1:0]        oen_o
);
  localparam int N_TWORDS = NPADS * NTHR;
  localparam int A_TEN_LO = N_TWORDS;
  localparam int A_TEN_HI = N_TWORDS + 1;
  localparam int A_OEN    = N_TWORDS + 2;
  localparam int A_OMASK  = N_TWORDS + 3;
  localparam int OM_W     = NLOW * NOPL;

  // tile mask words, one register per pad/threshold
  for (genvar w = 0; w < N_TWORDS; w++) begin : g_tword
    logic             ld;
    logic [NTILE-1:0] q;
    assign ld = we && (addr == AW'(w));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (ld) q <= wdata[NTILE-1:0];
    end
    assign tmask_o[w*NTILE +: NTILE] = q;
  end

  // outer-plane mask words, one per pad
  for (genvar p = 0; p < NPADS; p++) begin : g_oword
    logic            ld;
    logic [OM_W-1:0] q;
    assign ld = we && (addr == AW'(A_OMASK + p));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (ld) q <= wdata[OM_W-1:0];
    end
    assign omask_o[p*OM_W +: OM_W] = q;
  end

  // enable bits, sliced SLICE_W bits per pad
  logic [NPADS*NTHR-1:0] ten_q, ten_d;
  logic [NPADS*NLOW-1:0] oen_q, oen_d;

  always_comb begin
    ten_d = ten_q;
    oen_d = oen_q;
    for (int p = 0; p < NPADS; p++) begin
      for (int j = 0; j < NLOW; j++) begin
        if (we && addr == AW'(A_TEN_LO)) ten_d[p*NTHR + j]        = wdata[p*SLICE_W + j];
        if (we && addr == AW'(A_TEN_HI)) ten_d[p*NTHR + NLOW + j] = wdata[p*SLICE_W + j];
        if (we && addr == AW'(A_OEN))    oen_d[p*NLOW + j]        = wdata[p*SLICE_W + j];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ten_q <= '0;
      oen_q <= '0;
    end else begin
      ten_q <= ten_d;
      oen_q <= oen_d;
    end
  end

  assign ten_o = ten_q;
  assign oen_o = oen_q;

  // R10: enables change only through a write
  p_enables_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> ($stable(ten_o) && $stable(oen_o) && $stable(omask_o) && $stable(tmask_o)));
endmodule

// File: rtl/ccf_opl_stage.sv
module ccf_opl_stage
  import ccf_pkg::*;
#(
  parameter int NPADS = 8,
  parameter int NTILE = 32,
  parameter int NOPL  = 8,
  parameter int PAY_W = 13
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                valid_i,
  input  logic [NPADS*(THR_W+PAY_W)-1:0]      cand_i,
  input  logic [NTILE-1:0]                    tile_i,
  input  logic [NOPL-1:0]                     opl_i,
  input  logic [NPADS*NTHR*NTILE-1:0]         tmask_i,
  input  logic [NPADS*NTHR-1:0]               ten_i,
  input  logic [NPADS*NLOW*NOPL-1:0]          omask_i,
  input  logic [NPADS*NLOW-1:0]               oen_i,
  output logic                                valid_o,
  output logic [NPADS*(THR_W+PAY_W)-1:0]      cand_o,
  output logic [NTILE-1:0]                    tile_o,
  output logic [NPADS*NTILE-1:0]              tsel_o,
  output logic [NPADS-1:0]                    tchk_o
);
  localparam int CW = THR_W + PAY_W;

  logic [NPADS*CW-1:0]    cand_d;
  logic [NPADS*NTILE-1:0] tsel_d;
  logic [NPADS-1:0]       tchk_d;

  for (genvar p = 0; p < NPADS; p++) begin : g_pad
    logic [THR_W-1:0] thr, thr_n;
    logic             low, hit, opl_ok;
    logic [1:0]       lidx;
    logic [2:0]       tidx;
    logic [NOPL-1:0]  omap;

    always_comb begin
      thr    = cand_i[p*CW +: THR_W];
      low    = thr_is_low(thr);
      lidx   = low ? 2'(thr - 3'd1) : 2'd0;
      omap   = omask_i[(p*NLOW + int'(lidx))*NOPL +: NOPL];
      opl_ok = !oen_i[p*NLOW + int'(lidx)] || (|(omap & opl_i));
      thr_n  = (!low || opl_ok) ? thr : '0;
      hit    = thr_is_cand(thr_n);
      tidx   = hit ? (thr_n - 3'd1) : 3'd0;
    end

    assign cand_d[p*CW +: THR_W]          = thr_n;
    assign cand_d[p*CW + THR_W +: PAY_W]  = cand_i[p*CW + THR_W +: PAY_W];
    assign tsel_d[p*NTILE +: NTILE]       = tmask_i[(p*NTHR + int'(tidx))*NTILE +: NTILE];
    assign tchk_d[p]                      = hit && ten_i[p*NTHR + int'(tidx)];

    // R6: high codes leave this stage untouched
    p_high_skips_opl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && thr >= 3'd4 && thr <= 3'd6) |=> (cand_o[p*CW +: CW] == $past(cand_i[p*CW +: CW])));

    // R5: enabled low check with no mapped flag clears the code
    p_opl_reject_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && low && oen_i[p*NLOW + int'(lidx)] && !(|(omap & opl_i)))
        |=> (cand_o[p*CW +: THR_W] == '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_o <= 1'b0;
    else        valid_o <= valid_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_o <= '0;
      tile_o <= '0;
      tsel_o <= '0;
      tchk_o <= '0;
    end else if (valid_i) begin
      cand_o <= cand_d;
      tile_o <= tile_i;
      tsel_o <= tsel_d;
      tchk_o <= tchk_d;
    end
  end

  // R1: first half of the two-cycle latency
  p_stage1_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (valid_o == $past(valid_i)));
endmodule

// File: rtl/ccf_tile_stage.sv
module ccf_tile_stage
  import ccf_pkg::*;
#(
  parameter int NPADS = 8,
  parameter int NTILE = 32,
  parameter int PAY_W = 13
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            valid_i,
  input  logic [NPADS*(THR_W+PAY_W)-1:0]  cand_i,
  input  logic [NTILE-1:0]                tile_i,
  input  logic [NPADS*NTILE-1:0]          tsel_i,
  input  logic [NPADS-1:0]                tchk_i,
  output logic                            valid_o,
  output logic [NPADS*(THR_W+PAY_W)-1:0]  cand_o
);
  localparam int CW = THR_W + PAY_W;

  logic [NPADS*CW-1:0] cand_d;

  for (genvar p = 0; p < NPADS; p++) begin : g_pad
    logic confirmed;
    assign confirmed = !tchk_i[p] || (|(tsel_i[p*NTILE +: NTILE] & tile_i));
    assign cand_d[p*CW +: THR_W] = confirmed ? cand_i[p*CW +: THR_W] : '0;
    assign cand_d[p*CW + THR_W +: PAY_W] = cand_i[p*CW + THR_W +: PAY_W];

    // R7: payload survives the tile stage
    p_payload_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
      valid_i |=> (cand_o[p*CW + THR_W +: PAY_W] == $past(cand_i[p*CW + THR_W +: PAY_W])));

    // R4: no tile check requested means slot is copied
    p_unchecked_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && !tchk_i[p]) |=> (cand_o[p*CW +: CW] == $past(cand_i[p*CW +: CW])));

    // R3: requested check with no mapped tile clears the code
    p_tile_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && tchk_i[p] && !(|(tsel_i[p*NTILE +: NTILE] & tile_i)))
        |=> (cand_o[p*CW +: THR_W] == '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_o <= 1'b0;
    else        valid_o <= valid_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cand_o <= '0;
    else if (valid_i) cand_o <= cand_d;
  end

  // R1: second half of the two-cycle latency
  p_stage2_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (valid_o == $past(valid_i)));
endmodule

// File: rtl/ccf_confirm_filter.sv
module ccf_confirm_filter
  import ccf_pkg::*;
#(
  parameter int NPADS = 8,
  parameter int NTILE = 32,
  parameter int NOPL  = 8,
  parameter int PAY_W = 13,
  parameter int AW    = 6,
  parameter int DW    = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            in_valid,
  input  logic [NPADS*(THR_W+PAY_W)-1:0]  in_cand,
  input  logic [NTILE-1:0]                in_tile,
  input  logic [NOPL-1:0]                 in_opl,
  input  logic                            cfg_we,
  input  logic [AW-1:0]                   cfg_addr,
  input  logic [DW-1:0]                   cfg_wdata,
  output logic                            out_valid,
  output logic [NPADS*(THR_W+PAY_W)-1:0]  out_cand
);
  localparam int CW = THR_W + PAY_W;

  logic [NPADS*NTHR*NTILE-1:0] tmask;
  logic [NPADS*NTHR-1:0]       ten;
  logic [NPADS*NLOW*NOPL-1:0]  omask;
  logic [NPADS*NLOW-1:0]       oen;

  logic                        s1_valid;
  logic [NPADS*CW-1:0]         s1_cand;
  logic [NTILE-1:0]            s1_tile;
  logic [NPADS*NTILE-1:0]      s1_tsel;
  logic [NPADS-1:0]            s1_tchk;

  ccf_cfg_bank #(.NPADS(NPADS), .NTILE(NTILE), .NOPL(NOPL), .AW(AW), .DW(DW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .tmask_o(tmask), .ten_o(ten), .omask_o(omask), .oen_o(oen)
  );

  ccf_opl_stage #(.NPADS(NPADS), .NTILE(NTILE), .NOPL(NOPL), .PAY_W(PAY_W)) u_opl (
    .clk(clk), .rst_n(rst_n), .valid_i(in_valid), .cand_i(in_cand),
    .tile_i(in_tile), .opl_i(in_opl), .tmask_i(tmask), .ten_i(ten),
    .omask_i(omask), .oen_i(oen), .valid_o(s1_valid), .cand_o(s1_cand),
    .tile_o(s1_tile), .tsel_o(s1_tsel), .tchk_o(s1_tchk)
  );

  ccf_tile_stage #(.NPADS(NPADS), .NTILE(NTILE), .PAY_W(PAY_W)) u_tile (
    .clk(clk), .rst_n(rst_n), .valid_i(s1_valid), .cand_i(s1_cand),
    .tile_i(s1_tile), .tsel_i(s1_tsel), .tchk_i(s1_tchk),
    .valid_o(out_valid), .cand_o(out_cand)
  );

  for (genvar p = 0; p < NPADS; p++) begin : g_chk
    // R2: input codes stay within 0..6
    p_code_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> (in_cand[p*CW +: THR_W] != 3'd7));
    // R2: an empty slot stays empty through stage one
    p_empty_stays_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_cand[p*CW +: THR_W] == '0) |=> (s1_cand[p*CW +: THR_W] == '0));
  end
endmodule

// File: tb/tb_ccf_confirm_filter.sv
module tb_ccf_confirm_filter;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [127:0] in_cand;
  logic [31:0]  in_tile;
  logic [7:0]   in_opl;
  logic         cfg_we;
  logic [5:0]   cfg_addr;
  logic [31:0]  cfg_wdata;
  logic         out_valid;
  logic [127:0] out_cand;

  int n_chk  = 0;
  int n_fail = 0;
  logic [127:0] res_a, res_b;
  logic         va, vb, vc;

  always #2.5 clk = ~clk;

  ccf_confirm_filter dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cand(in_cand),
    .in_tile(in_tile), .in_opl(in_opl), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .out_valid(out_valid), .out_cand(out_cand)
  );

  function automatic logic [127:0] put(logic [127:0] v, int p, logic [2:0] t);
    logic [127:0] r = v;
    r[p*16 +: 16] = {13'(13'h0A0 + p), t};
    return r;
  endfunction

  function automatic logic [15:0] slot(logic [2:0] t, int p);
    return {13'(13'h0A0 + p), t};
  endfunction

  task automatic check(string req, logic [127:0] got, logic [127:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0; in_cand = '0; in_tile = '0; in_opl = '0;
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic cfg_wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // one crossing; result sampled two edges after entry
  task automatic xing(logic [127:0] c, logic [31:0] t, logic [7:0] o);
    @(negedge clk);
    in_valid = 1'b1; in_cand = c; in_tile = t; in_opl = o;
    @(negedge clk);
    in_valid = 1'b0; in_tile = '0; in_opl = '0;
    @(negedge clk);
    va = out_valid; res_a = out_cand;
  endtask

  task automatic t_reset();
    logic [127:0] c = '0;
    rst_n = 1'b0; in_valid = 1'b0; in_cand = '0; in_tile = '0; in_opl = '0;
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    #1;
    check("R12 out_valid in reset", {127'd0, out_valid}, '0);
    check("R12 out_cand in reset", out_cand, '0);
    do_reset();
    for (int p = 0; p < 8; p++) c = put(c, p, 3'(p % 7));
    xing(c, '0, '0);
    check("R12 default config passes all", res_a, c);
  endtask

  task automatic t_empty();
    logic [127:0] c = '0;
    do_reset();
    cfg_wr(6'd48, 32'h7777_7777);
    cfg_wr(6'd49, 32'h7777_7777);
    cfg_wr(6'd50, 32'h7777_7777);
    for (int p = 0; p < 8; p++) c = put(c, p, 3'd0);
    xing(c, '0, '0);
    check("R2 empty slots unchanged", res_a, c);
  endtask

  task automatic t_tile();
    logic [127:0] c = '0, e;
    do_reset();
    cfg_wr(6'(2*6 + 4), 32'h0000_0200);  // pad2 thr5 <- tile 9
    cfg_wr(6'(6*6 + 1), 32'h0000_0200);  // pad6 thr2 <- tile 9
    cfg_wr(6'(0*6 + 4), 32'h0000_0000);
    cfg_wr(6'd49, 32'h0000_0200);        // high enable pad2 thr5
    cfg_wr(6'd48, 32'h0200_0000);        // low enable pad6 thr2
    c = put(c, 2, 3'd5); c = put(c, 6, 3'd2); c = put(c, 0, 3'd5);
    xing(c, 32'h0000_0200, '0);
    check("R8 shared tile bit confirms both pads", res_a, c);
    xing(c, 32'h0000_0400, '0);
    e = c; e[2*16 +: 16] = slot(3'd0, 2); e[6*16 +: 16] = slot(3'd0, 6);
    check("R3 unmapped tile rejects, R7 payload kept", res_a, e);
    check("R4 disabled pad0 passes", {112'd0, res_a[15:0]}, {112'd0, slot(3'd5, 0)});
    xing(c, '0, '0);
    check("R3 no tile rejects", res_a, e);
  endtask

  task automatic t_back_to_back();
    logic [127:0] c = '0, e;
    do_reset();
    cfg_wr(6'(3*6 + 3), 32'h8000_0000);  // pad3 thr4 <- tile 31
    cfg_wr(6'd49, 32'h0000_1000);
    c = put(c, 3, 3'd4);
    @(negedge clk);
    in_valid = 1'b1; in_cand = c; in_tile = 32'h8000_0000;
    @(negedge clk);
    in_cand = c; in_tile = '0;
    @(negedge clk);
    in_valid = 1'b0;
    va = out_valid; res_a = out_cand;
    @(negedge clk);
    vb = out_valid; res_b = out_cand;
    @(negedge clk);
    vc = out_valid;
    e = c; e[3*16 +: 16] = slot(3'd0, 3);
    check("R1 valid first", {127'd0, va}, 128'd1);
    check("R1 valid second", {127'd0, vb}, 128'd1);
    check("R1 valid drops", {127'd0, vc}, 128'd0);
    check("R13 confirmed in own crossing", res_a, c);
    check("R13 earlier tile does not confirm", res_b, e);
  endtask

  task automatic t_opl();
    logic [127:0] c = '0, e;
    do_reset();
    cfg_wr(6'd52, 32'h0000_0008);        // pad1 thr1 <- flag 3
    cfg_wr(6'd54, 32'h0000_0000);        // pad3 masks empty
    cfg_wr(6'd50, 32'h0000_7010);        // oen pad1 thr1, pad3 all
    c = put(c, 1, 3'd1); c = put(c, 3, 3'd4);
    xing(c, '0, 8'h08);
    check("R5 mapped flag passes; R6 high ignores opl", res_a, c);
    xing(c, '0, 8'h10);
    e = c; e[1*16 +: 16] = slot(3'd0, 1);
    check("R5 unmapped flag rejects", res_a, e);
    c = '0; c = put(c, 3, 3'd2);
    xing(c, '0, 8'hFF);
    e = c; e[3*16 +: 16] = slot(3'd0, 3);
    check("R5 empty mask rejects low", res_a, e);
  endtask

  task automatic t_series();
    logic [127:0] c = '0, e;
    do_reset();
    cfg_wr(6'd52, 32'h0000_0008);
    cfg_wr(6'd50, 32'h0000_0010);
    cfg_wr(6'(1*6 + 0), 32'h0000_0001);
    cfg_wr(6'd48, 32'h0000_0010);
    c = put(c, 1, 3'd1);
    e = c; e[1*16 +: 16] = slot(3'd0, 1);
    xing(c, 32'h1, 8'h08);
    check("R9 both ok passes", res_a, c);
    xing(c, 32'h2, 8'h08);
    check("R9 tile fails rejects", res_a, e);
    xing(c, 32'h1, 8'h01);
    check("R9 opl fails rejects", res_a, e);
  endtask

  task automatic t_cfg_timing();
    logic [127:0] c = '0, e;
    do_reset();
    cfg_wr(6'(2*6 + 4), 32'h0000_0200);
    cfg_wr(6'd49, 32'h0000_0200);
    c = put(c, 2, 3'd5);
    e = c; e[2*16 +: 16] = slot(3'd0, 2);
    // write in entry cycle
    @(negedge clk);
    in_valid = 1'b1; in_cand = c; in_tile = 32'h0000_0200;
    cfg_we = 1'b1; cfg_addr = 6'(2*6 + 4); cfg_wdata = '0;
    @(negedge clk);
    in_valid = 1'b0; cfg_we = 1'b0;
    @(negedge clk);
    check("R11 entry-cycle write not seen", out_cand, c);
    xing(c, 32'h0000_0200, '0);
    check("R11 next crossing sees write", res_a, e);
    // write while in flight
    cfg_wr(6'(2*6 + 4), 32'h0000_0200);
    @(negedge clk);
    in_valid = 1'b1; in_cand = c; in_tile = 32'h0000_0200;
    @(negedge clk);
    in_valid = 1'b0;
    cfg_we = 1'b1; cfg_addr = 6'(2*6 + 4); cfg_wdata = '0;
    @(negedge clk);
    cfg_we = 1'b0;
    check("R11 in-flight write not seen", out_cand, c);
  endtask

  task automatic t_unmapped();
    logic [127:0] c = '0;
    do_reset();
    for (int a = 59; a < 64; a++) cfg_wr(6'(a), 32'hFFFF_FFFF);
    c = put(c, 0, 3'd4); c = put(c, 5, 3'd1);
    xing(c, '0, '0);
    check("R10 unmapped writes have no effect", res_a, c);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_empty();
    t_tile();
    t_back_to_back();
    t_opl();
    t_series();
    t_cfg_timing();
    t_unmapped();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule